// File: doc/BRIEF.md
# Dithered 14-bit PWM generator

This block drives a single active-low pulse output whose average low time is set by a 14-bit duty word. An external low-pass filter turns the output into an analog level. Each short basic period of 1024 clocks carries a coarse low pulse. Thirty-two basic periods make one frame of 32768 clocks. Across the frame, the fine part of the duty word lengthens some of the coarse pulses by small steps. Most of the duty resolution therefore lives in the fast period, which lets the external filter use a short time constant.

Software sets the duty through a small register bus with three locations. One holds the coarse byte. One holds the fine field in its upper six bits. The third holds a reload-enable flag. The working duty latch takes a new value only at the end of a frame, and only while reload is enabled. Because of this, a half-written duty word, or a change that lasts less than a frame, never reaches the output. An interrupt pulse marks the start of every frame.

Top module: `dither_pwm14`

## Requirements
- R1: A synchronous active-high reset holds `pwmN` at 1, `irq` at 0, the duty latch at 0 and every bus register at 0. With a zero latch, the first frame after reset has no low cycle.
- R2: Bus map, accessed through `addr`. Address 0 is the fine register: bits 7..2 are stored, and bits 1..0 always read back as 0. Address 1 is the coarse register (8 bits). Address 2 bit 0 is the reload-enable flag. Writes to address 3 are ignored, and reads from it return 0. `rdData` shows the addressed register in the same cycle.
- R3: A reload sets the latch to the coarse register in bits 13..6 and the fine field in bits 5..0.
- R4: A free-running frame position counts 0 to 32767 and then wraps. Its low 10 bits are the phase within a basic period. Its upper 5 bits are the slot number s (0 to 31).
- R5: For coarse value H and fine value F, the low width of slot s is W(s) = 4·H + 2·(⌊(s+1)·F/32⌋ − ⌊s·F/32⌋). The output is registered: after the n-th clock edge following reset, `pwmN` is 0 exactly when the phase of position n−1 is below the W of that position's slot.
- R6: Over one frame, the number of low cycles equals 2 × the latch value.
- R7: The latch changes only on the edge that ends frame position 32767, and only if reload-enable is 1 at that edge. It keeps its value at every other edge.
- R8: If reload-enable and the registers are changed and restored inside one frame, without spanning a frame end, the output is the same as if nothing had been written.
- R9: `irq` is a one-cycle pulse after every frame-end edge. The first pulse comes 32768 cycles after reset, and later pulses come every 32768 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the register at `addr` |
| pwmN | output | 1 | Active-low PWM output |
| irq | output | 1 | Frame-start interrupt pulse |

## Verification
A read is due in the same cycle that `addr` is set. A write is stored on the next edge, but it reaches the output only through the latch. The latch picks it up at the next frame-end edge, and the new duty shows from the first cycle of the following frame. `pwmN` always trails the frame position by one register stage. `irq` rises on the 32768th edge after reset and on every 32768th edge after that. The bench keeps its own cycle-accurate model of the position, the registers and the latch. It updates the model on each rising edge and compares `pwmN` and `irq` on the falling edge that follows. Frame totals are checked when each `irq` pulse is seen.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int BUS_W = 8;
  localparam logic [1:0] ADDR_FINE   = 2'd0;
  localparam logic [1:0] ADDR_COARSE = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic frameEnd;  // frame position is at its last cycle
    logic reloadGo;  // latch should load on this edge
  } dpwm_strb_t;
endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reloadEn,
  output logic [BASE_W-1:0]  phase,
  output logic [FRAME_W-1:0] slot,
  output dpwm_strb_t         strb
);
  localparam int POS_W = BASE_W + FRAME_W;

  logic [POS_W-1:0] posCnt;

  always_ff @(posedge clk) begin
    if (rst) posCnt <= '0;
    else     posCnt <= posCnt + POS_W'(1);
  end

  assign phase         = posCnt[BASE_W-1:0];
  assign slot          = posCnt[POS_W-1:BASE_W];
  assign strb.frameEnd = &posCnt;
  assign strb.reloadGo = (&posCnt) & reloadEn;
endmodule

// File: rtl/dpwm_spread.sv
module dpwm_spread #(
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 5,
  parameter int HI_W    = 8,
  parameter int FINE_W  = 6
) (
  input  logic [HI_W-1:0]    coarse,
  input  logic [FINE_W-1:0]  fine,
  input  logic [FRAME_W-1:0] slot,
  output logic [BASE_W:0]    lowWidth
);
  localparam int PW        = FRAME_W + FINE_W + 1;
  localparam int W_W       = BASE_W + 1;
  localparam int COARSE_SH = BASE_W - HI_W;
  localparam int UNIT_SH   = BASE_W + FRAME_W - HI_W - FINE_W;

  logic [PW-1:0] prodNext, prodCur, extUnits;

  always_comb begin
    prodNext = (PW'(slot) + PW'(1)) * PW'(fine);
    prodCur  = PW'(slot) * PW'(fine);
    extUnits = (prodNext >> FRAME_W) - (prodCur >> FRAME_W);
    lowWidth = (W_W'(coarse) << COARSE_SH) + (W_W'(extUnits) << UNIT_SH);
  end
endmodule

// File: rtl/dpwm_datapath.sv
module dpwm_datapath
  import dpwm_pkg::*;
#(
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 5,
  parameter int HI_W    = 8,
  parameter int FINE_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [1:0]             addr,
  input  logic [BUS_W-1:0]       wrData,
  output logic [BUS_W-1:0]       rdData,
  input  dpwm_strb_t             strb,
  input  logic [BASE_W-1:0]      phase,
  input  logic [FRAME_W-1:0]     slot,
  output logic                   reloadEn,
  output logic [HI_W+FINE_W-1:0] latchVal,
  output logic                   pwmN,
  output logic                   irq
);
  localparam int LAT_W = HI_W + FINE_W;
  localparam int PAD_W = BUS_W - FINE_W;

  logic [HI_W-1:0]   coarseReg;
  logic [FINE_W-1:0] fineReg;
  logic              relReg;
  logic [BASE_W:0]   lowWidth;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseReg <= '0;
      fineReg   <= '0;
      relReg    <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        ADDR_FINE:   fineReg   <= wrData[BUS_W-1 -: FINE_W];
        ADDR_COARSE: coarseReg <= wrData[HI_W-1:0];
        ADDR_CTRL:   relReg    <= wrData[0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_FINE:   rdData = {fineReg, PAD_W'(0)};
      ADDR_COARSE: rdData = BUS_W'(coarseReg);
      ADDR_CTRL:   rdData = BUS_W'(relReg);
      default:     rdData = '0;
    endcase
  end

  assign reloadEn = relReg;

  always_ff @(posedge clk) begin
    if (rst)                latchVal <= '0;
    else if (strb.reloadGo) latchVal <= {coarseReg, fineReg};
  end

  dpwm_spread #(
    .BASE_W(BASE_W), .FRAME_W(FRAME_W), .HI_W(HI_W), .FINE_W(FINE_W)
  ) u_spread (
    .coarse  (latchVal[LAT_W-1:FINE_W]),
    .fine    (latchVal[FINE_W-1:0]),
    .slot    (slot),
    .lowWidth(lowWidth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmN <= 1'b1;
      irq  <= 1'b0;
    end else begin
      pwmN <= ~({1'b0, phase} < lowWidth);
      irq  <= strb.frameEnd;
    end
  end
endmodule

// File: rtl/dither_pwm14.sv
module dither_pwm14
  import dpwm_pkg::*;
#(
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 5,
  parameter int HI_W    = 8,
  parameter int FINE_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  output logic             pwmN,
  output logic             irq
);
  localparam int LAT_W = HI_W + FINE_W;

  logic [BASE_W-1:0]  phase;
  logic [FRAME_W-1:0] slot;
  logic               reloadEn;
  logic [LAT_W-1:0]   latchVal;
  dpwm_strb_t         strb;

  dpwm_ctrl #(.BASE_W(BASE_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst(rst), .reloadEn(reloadEn),
    .phase(phase), .slot(slot), .strb(strb)
  );

  dpwm_datapath #(
    .BASE_W(BASE_W), .FRAME_W(FRAME_W), .HI_W(HI_W), .FINE_W(FINE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .strb(strb), .phase(phase), .slot(slot),
    .reloadEn(reloadEn), .latchVal(latchVal), .pwmN(pwmN), .irq(irq)
  );
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 5,
  parameter int LAT_W   = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              pwmN,
  input logic              irq,
  input logic [1:0]        addr,
  input logic [7:0]        rdData,
  input logic [BASE_W-1:0] phase,
  input logic [LAT_W-1:0]  latchVal,
  input logic              frameEnd,
  input logic              reloadEn
);
  localparam int POS_W = BASE_W + FRAME_W;

  logic [POS_W-1:0] sinceFrame;
  always_ff @(posedge clk) begin
    if (rst) sinceFrame <= '0;
    else     sinceFrame <= sinceFrame + POS_W'(1);
  end

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sinceFrame == '0));

  p_low_starts_period_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pwmN) |-> (phase == BASE_W'(1)));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(frameEnd && reloadEn) |=> $stable(latchVal));

  p_fine_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd0) |-> (rdData[1:0] == 2'b00));
endmodule

bind dither_pwm14 dpwm_checker #(
  .BASE_W(BASE_W), .FRAME_W(FRAME_W), .LAT_W(HI_W + FINE_W)
) u_chk (
  .clk(clk), .rst(rst), .pwmN(pwmN), .irq(irq), .addr(addr),
  .rdData(rdData), .phase(phase), .latchVal(latchVal),
  .frameEnd(strb.frameEnd), .reloadEn(reloadEn)
);

// File: tb/tb_dither_pwm14.sv
module tb_dither_pwm14;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       pwmN, irq;

  always #4 clk = ~clk;

  dither_pwm14 dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmN(pwmN), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  int mCnt, mLatch, mHi, mLo, mRel;
  bit expPwm = 1, expIrq = 0;
  int usedLatch;

  function automatic int slotWidth(int lat, int s);
    int hi = lat / 64;
    int f  = lat % 64;
    return 4 * hi + 2 * (((s + 1) * f) / 32 - (s * f) / 32);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mLatch = 0; mHi = 0; mLo = 0; mRel = 0;
      expPwm = 1; expIrq = 0; usedLatch = 0;
    end else begin
      expPwm = !((mCnt % 1024) < slotWidth(mLatch, mCnt / 1024));
      expIrq = (mCnt == 32767);
      usedLatch = mLatch;
      if (mCnt == 32767 && mRel != 0) mLatch = mHi * 64 + (mLo / 4);
      mCnt = (mCnt + 1) % 32768;
      if (wrEn) begin
        case (addr)
          2'd0: mLo = wrData;
          2'd1: mHi = wrData;
          2'd2: mRel = wrData[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle monitor
  int cyc = 0, lastIrq = 0, lowAcc = 0, frameIdx = 0;
  int frameLow[8];
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      check("R5 pwmN vs model", int'(pwmN), int'(expPwm));
      check("R9 irq vs model", int'(irq), int'(expIrq));
      if (!pwmN) lowAcc++;
      if (irq) begin
        check("R6 frame low count", lowAcc, 2 * usedLatch);
        check("R9 irq spacing", cyc - lastIrq, 32768);
        if (frameIdx < 8) frameLow[frameIdx] = lowAcc;
        frameIdx++;
        lowAcc = 0;
        lastIrq = cyc;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, int'(rdData), exp);
  endtask

  task automatic waitFrame();
    do @(negedge clk); while (irq !== 1'b1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pwmN", int'(pwmN), 1);
    check("R1 reset irq", int'(irq), 0);
    addr = 2'd1; #1;
    check("R1 reset coarse reg", int'(rdData), 0);
    @(negedge clk); #1 rst = 1'b0;

    rd(2'd0, 0, "R1 fine reg after reset");
    wr(2'd1, 8'h40);
    wr(2'd0, 8'hA7);
    rd(2'd0, 8'hA4, "R2 fine low bits read as zero");
    rd(2'd1, 8'h40, "R2 coarse readback");
    wr(2'd3, 8'hFF);
    rd(2'd3, 0, "R2 address 3 ignored");
    rd(2'd1, 8'h40, "R2 coarse unchanged by addr 3");
    wr(2'd2, 8'h01);
    rd(2'd2, 1, "R2 reload flag readback");

    waitFrame();
    check("R1 first frame has no low cycle", frameLow[0], 0);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFC);
    repeat (2000) @(negedge clk);
    wr(2'd2, 8'h01);
    repeat (100) @(negedge clk);
    wr(2'd2, 8'h00);

    waitFrame();
    check("R3 frame with H=0x40 F=41", frameLow[1], 8274);
    wr(2'd2, 8'h01);

    waitFrame();
    check("R8 mid-frame pulse left latch", frameLow[2], 8274);

    waitFrame();
    check("R7 reload at frame end H=0xFF F=63", frameLow[3], 32766);
    check("R4 frames counted", frameIdx, 4);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule